// File: doc/BRIEF.md
# Three-Channel Interval Timer Host Interface

This block is the processor-facing side of a programmable interval timer with three 16-bit down-counters. A host reaches it over an 8-bit I/O bus with a two-bit address, a chip select, a read strobe and a write strobe. Offsets 0, 1 and 2 carry reload data and count or status reads for one channel each. Offset 3 is a write-only command port. The value of a command byte decides whether it is a channel setup word, a single-channel count snapshot or a multi-channel read-back.

Each channel keeps its byte-access mode, counting mode and decimal flag. It steps through low and high bytes for reload writes and count reads, and it holds snapshots of the count and of a status byte until the host has read them out. Behind every channel sits a small down-counter. It decrements on a shared count-enable tick while its gate is high. Two behaviours are modelled: a one-shot, where OUT rises at terminal count, and a periodic rate generator, where OUT dips low for one tick before a reload. The counter also reports whether a newly written reload value has reached it yet.

Top module: `pit_host_iface`

## Requirements
- R1: After reset every OUT is high, every channel reports a pending reload (null flag set) and a count of zero, and its access mode is 00, so an unlatched read returns the low count byte, which is 0x00.
- R2: Offsets 0 to 2 return channel data on a read. A read of offset 3 returns 0x00, and rdata is 0x00 whenever no read is active.
- R3: A command byte with bits 7:6 not equal to 11 and bits 5:4 not equal to 00 is a setup word for the channel numbered by bits 7:6. It stores the decimal flag from bit 0, the mode from bits 3:1 and the access mode from bits 5:4. Mode codes 110 and 111 are stored as 010 and 011. The word sets the channel's null flag and returns its byte pointer to the low byte.
- R4: A status byte holds the stored access mode in bits 5:4, the mode in bits 3:1, the decimal flag in bit 0, the null flag in bit 6 and the OUT level in bit 7.
- R5: Reload writes follow the access mode. With 01 the byte is the low byte and the high byte is zero. With 10 the byte is the high byte and the low byte is zero. With 11 the low byte is written first and then the high byte. A reload is complete only after its last byte.
- R6: Reads without a snapshot return the live count in the same byte order. In mode 11 reads share the byte pointer with writes and alternate between low and high.
- R7: A command byte with bits 5:4 equal to 00 and bits 7:6 naming a channel copies that channel's count into a snapshot without disturbing the count. The snapshot is returned until all of its bytes have been read. Further snapshot requests for that channel have no effect until then.
- R8: A command byte with bits 7:6 equal to 11 is a read-back. Bits 1, 2 and 3 pick channels 0, 1 and 2. Bit 5 at 0 captures the count, and bit 4 at 0 captures the status byte. When both are held, the first read returns the status and later reads return the count bytes.
- R9: A completed reload moves into the counter on the next tick whether or not the gate is high, and this clears the null flag. While the gate is low, ticks do not change a running count.
- R10: Mode codes 000, 001, 100 and 101 are one-shot. OUT goes low two cycles after the setup word and goes high on the tick at which the count reaches zero.
- R11: Mode codes 010 and 011 are periodic. OUT goes low on the tick at which the count reaches one. On the next tick the counter reloads and OUT goes high again.
- R12: A reload value of zero counts as 65536 in binary and as 10000 in decimal, so the first decrement after it gives 0xFFFF or 0x9999. With the decimal flag set, the count decrements digit by digit.
- R13: OUT changes only on a tick or in the cycle in which a setup word takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for bus accesses |
| rd | input | 1 | Read strobe, one cycle per byte read |
| wr | input | 1 | Write strobe, one cycle per byte written |
| addr | input | 2 | Offset: 0 to 2 channel data, 3 command port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle rd is high |
| tick | input | 1 | Count enable shared by all channels |
| gate | input | 3 | Per-channel gate, one bit per channel |
| out | output | 3 | Per-channel OUT level |

## Verification
The hardest states to reach are the ones where a channel holds a status snapshot and a count snapshot at the same time, or where a second snapshot request arrives while an earlier count snapshot has been only partly read. Neither can be seen until the host starts reading. The bench reaches them by sequence. It issues a count snapshot, lets the counter move on, repeats the request and then reads both bytes, expecting the first value. A combined read-back that captures both snapshots is then read three times, and the order of the bytes that come back is checked.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
    localparam int NUM_CH   = 3;
    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int DIGITS   = CNT_W / 4;
    localparam int CFG_W    = 6;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_LOHI = 2'b11
    } acc_mode_t;

    typedef struct packed {
        acc_mode_t  acc;
        logic [2:0] mode;
        logic       dec;
    } chan_cfg_t;

    function automatic logic [2:0] mode_fold(input logic [2:0] m);
        return m[1] ? {1'b0, m[1:0]} : m;
    endfunction

    function automatic logic is_periodic(input logic [2:0] m);
        return m[1];
    endfunction

    function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] v,
                                                    input logic dec);
        logic [CNT_W-1:0] r;
        logic borrow;
        if (!dec) return v - CNT_W'(1);
        r = v;
        borrow = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (borrow) begin
                if (v[d*4 +: 4] == 4'd0) begin
                    r[d*4 +: 4] = 4'd9;
                end else begin
                    r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
                    borrow = 1'b0;
                end
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pit_counter.sv
`timescale 1ns/1ps
module pit_counter
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             gate,
    input  logic             cfg_stb,
    input  logic             periodic,
    input  logic             dec,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             out,
    output logic             nullc
);
    logic             pend;
    logic             run;
    logic [CNT_W-1:0] nxt;

    assign nxt = count_step(count, dec);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            out   <= 1'b1;
            nullc <= 1'b1;
            pend  <= 1'b0;
            run   <= 1'b0;
        end else begin
            if (load_stb) begin
                pend  <= 1'b1;
                nullc <= 1'b1;
            end
            if (cfg_stb) begin
                out   <= periodic;
                run   <= 1'b0;
                pend  <= 1'b0;
                nullc <= 1'b1;
            end else if (tick) begin
                if (pend || load_stb) begin
                    count <= reload;
                    pend  <= 1'b0;
                    nullc <= 1'b0;
                    run   <= 1'b1;
                    if (periodic) out <= 1'b1;
                end else if (run && gate) begin
                    if (periodic) begin
                        if (count == CNT_W'(1)) begin
                            count <= reload;
                            out   <= 1'b1;
                        end else begin
                            count <= nxt;
                            out   <= (nxt != CNT_W'(1));
                        end
                    end else begin
                        count <= nxt;
                        if (nxt == '0) out <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pit_chan_regs.sv
`timescale 1ns/1ps
module pit_chan_regs
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_stb,
    input  chan_cfg_t         ctrl_cfg,
    input  logic              snap_stb,
    input  logic              stat_stb,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              out,
    input  logic              nullc,
    output chan_cfg_t         cfg,
    output logic              cfg_stb,
    output logic              load_stb,
    output logic [CNT_W-1:0]  reload,
    output logic [BYTE_W-1:0] rd_byte
);
    logic              ptr;
    logic [BYTE_W-1:0] lo_hold;
    logic              cnt_held;
    logic              cnt_ptr;
    logic [CNT_W-1:0]  cnt_snap;
    logic              st_held;
    logic [BYTE_W-1:0] st_snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            cfg_stb  <= 1'b0;
            load_stb <= 1'b0;
            reload   <= '0;
            ptr      <= 1'b0;
            lo_hold  <= '0;
            cnt_held <= 1'b0;
            cnt_ptr  <= 1'b0;
            cnt_snap <= '0;
            st_held  <= 1'b0;
            st_snap  <= '0;
        end else begin
            cfg_stb  <= 1'b0;
            load_stb <= 1'b0;
            if (ctrl_stb) begin
                cfg     <= ctrl_cfg;
                cfg_stb <= 1'b1;
                ptr     <= 1'b0;
            end
            if (snap_stb && !cnt_held) begin
                cnt_snap <= count;
                cnt_held <= 1'b1;
                cnt_ptr  <= 1'b0;
            end
            if (stat_stb && !st_held) begin
                st_snap <= {out, nullc, cfg};
                st_held <= 1'b1;
            end
            if (wr_stb) begin
                unique case (cfg.acc)
                    ACC_LO: begin
                        reload   <= {{BYTE_W{1'b0}}, wdata};
                        load_stb <= 1'b1;
                    end
                    ACC_HI: begin
                        reload   <= {wdata, {BYTE_W{1'b0}}};
                        load_stb <= 1'b1;
                    end
                    ACC_LOHI: begin
                        if (!ptr) begin
                            lo_hold <= wdata;
                            ptr     <= 1'b1;
                        end else begin
                            reload   <= {wdata, lo_hold};
                            load_stb <= 1'b1;
                            ptr      <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (rd_stb) begin
                if (st_held) begin
                    st_held <= 1'b0;
                end else if (cnt_held) begin
                    if (cfg.acc == ACC_LOHI && !cnt_ptr) cnt_ptr <= 1'b1;
                    else cnt_held <= 1'b0;
                end else if (cfg.acc == ACC_LOHI) begin
                    ptr <= ~ptr;
                end
            end
        end
    end

    logic [CNT_W-1:0] src;
    logic             hi_sel;

    always_comb begin
        src    = cnt_held ? cnt_snap : count;
        hi_sel = cnt_held ? cnt_ptr : ptr;
        if (st_held) begin
            rd_byte = st_snap;
        end else begin
            unique case (cfg.acc)
                ACC_HI:   rd_byte = src[CNT_W-1:BYTE_W];
                ACC_LOHI: rd_byte = hi_sel ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
                default:  rd_byte = src[BYTE_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/pit_host_iface.sv
`timescale 1ns/1ps
module pit_host_iface
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              tick,
    input  logic [NUM_CH-1:0] gate,
    output logic [NUM_CH-1:0] out
);
    localparam logic [1:0] CMD_ADDR = 2'(NUM_CH);

    logic       cmd_wr;
    logic [1:0] wsel;
    logic       is_rdbk;
    logic       is_snap;
    logic       is_ctrl;
    chan_cfg_t  new_cfg;

    assign cmd_wr  = cs && wr && (addr == CMD_ADDR);
    assign wsel    = wdata[7:6];
    assign is_rdbk = cmd_wr && (wsel == 2'b11);
    assign is_snap = cmd_wr && (wsel != 2'b11) && (wdata[5:4] == 2'b00);
    assign is_ctrl = cmd_wr && (wsel != 2'b11) && (wdata[5:4] != 2'b00);

    always_comb begin
        new_cfg.acc  = acc_mode_t'(wdata[5:4]);
        new_cfg.mode = mode_fold(wdata[3:1]);
        new_cfg.dec  = wdata[0];
    end

    logic [NUM_CH-1:0]             cfg_stb;
    logic [NUM_CH-1:0]             nullc;
    logic [NUM_CH-1:0][BYTE_W-1:0] rd_byte;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chan_cfg_t        cfg;
        logic             load_stb;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] count;
        logic             ctrl_stb;
        logic             snap_stb;
        logic             stat_stb;

        assign ctrl_stb = is_ctrl && (wsel == 2'(i));
        assign snap_stb = (is_snap && (wsel == 2'(i))) ||
                          (is_rdbk && wdata[i+1] && !wdata[5]);
        assign stat_stb = is_rdbk && wdata[i+1] && !wdata[4];

        pit_chan_regs u_regs (
            .clk      (clk),
            .rst      (rst),
            .ctrl_stb (ctrl_stb),
            .ctrl_cfg (new_cfg),
            .snap_stb (snap_stb),
            .stat_stb (stat_stb),
            .wr_stb   (cs && wr && (addr == 2'(i))),
            .rd_stb   (cs && rd && (addr == 2'(i))),
            .wdata    (wdata),
            .count    (count),
            .out      (out[i]),
            .nullc    (nullc[i]),
            .cfg      (cfg),
            .cfg_stb  (cfg_stb[i]),
            .load_stb (load_stb),
            .reload   (reload),
            .rd_byte  (rd_byte[i])
        );

        pit_counter u_cnt (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .gate     (gate[i]),
            .cfg_stb  (cfg_stb[i]),
            .periodic (is_periodic(cfg.mode)),
            .dec      (cfg.dec),
            .load_stb (load_stb),
            .reload   (reload),
            .count    (count),
            .out      (out[i]),
            .nullc    (nullc[i])
        );
    end

    always_comb begin
        rdata = '0;
        if (cs && rd) begin
            unique case (addr)
                2'd0:    rdata = rd_byte[0];
                2'd1:    rdata = rd_byte[1];
                2'd2:    rdata = rd_byte[2];
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pit_host_checker.sv
`timescale 1ns/1ps
module pit_host_checker
    import pit_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              rd,
    input logic              wr,
    input logic [1:0]        addr,
    input logic [BYTE_W-1:0] wdata,
    input logic [BYTE_W-1:0] rdata,
    input logic              tick,
    input logic [NUM_CH-1:0] out,
    input logic [NUM_CH-1:0] cfg_stb,
    input logic [NUM_CH-1:0] nullc
);
    assert_idle_bus_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !(cs && rd) |-> (rdata == '0));

    assert_cmd_port_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && addr == 2'd3) |-> (rdata == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic setup_wr;
        assign setup_wr = cs && wr && (addr == 2'd3) && (wdata[7:6] == 2'(i)) &&
                          (wdata[5:4] != 2'b00);

        assert_setup_sets_null_R3: assert property (@(posedge clk) disable iff (rst)
            setup_wr |=> ##1 nullc[i]);

        assert_oneshot_out_low_R10: assert property (@(posedge clk) disable iff (rst)
            (setup_wr && !wdata[2]) |=> ##1 !out[i]);

        assert_periodic_out_high_R11: assert property (@(posedge clk) disable iff (rst)
            (setup_wr && wdata[2]) |=> ##1 out[i]);

        assert_out_moves_on_tick_R13: assert property (@(posedge clk) disable iff (rst)
            (!tick && !cfg_stb[i]) |=> $stable(out[i]));

        assert_null_clears_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
            $fell(nullc[i]) |-> $past(tick));
    end
endmodule

bind pit_host_iface pit_host_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .rd      (rd),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .tick    (tick),
    .out     (out),
    .cfg_stb (cfg_stb),
    .nullc   (nullc)
);

// File: tb/tb_pit_host_iface.sv
`timescale 1ns/1ps
module tb_pit_host_iface;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, tick = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] gate = 3'b111;
    logic [2:0] out;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pit_host_iface dut (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate), .out(out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1'b1; rd = 1'b1; addr = a;
        #2 d = rdata;
        @(negedge clk); cs = 1'b0; rd = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 out after reset", 16'(out), 16'h7);
        bus_rd(2'd0, d);
        check("R1 unlatched read after reset", 16'(d), 16'h00);
        bus_wr(2'd3, 8'hE4);
        bus_rd(2'd1, d);
        check("R1 status after reset", 16'(d), 16'hC0);
        bus_rd(2'd3, d);
        check("R2 command port read", 16'(d), 16'h00);
        idle();
        check("R2 rdata idle", 16'(rdata), 16'h00);
    endtask

    task automatic t_oneshot();
        logic [7:0] d;
        bus_wr(2'd3, 8'h30);
        idle();
        check("R10 out low after setup", 16'(out[0]), 16'h0);
        bus_wr(2'd0, 8'h03);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd3, 8'hE2);
        bus_rd(2'd0, d);
        check("R4 R3 status after setup", 16'(d), 16'h70);
        pulse_tick();
        pulse_tick();
        pulse_tick();
        check("R10 out low before zero", 16'(out[0]), 16'h0);
        pulse_tick();
        check("R10 out high at zero", 16'(out[0]), 16'h1);
        bus_wr(2'd3, 8'hE2);
        bus_rd(2'd0, d);
        check("R9 null cleared after transfer", 16'(d), 16'hB0);
    endtask

    task automatic t_periodic_snap();
        logic [7:0] lo, hi;
        bus_wr(2'd3, 8'h74);
        bus_wr(2'd1, 8'h05);
        bus_wr(2'd1, 8'h00);
        pulse_tick();
        pulse_tick();
        pulse_tick();
        bus_wr(2'd3, 8'h40);
        pulse_tick();
        bus_wr(2'd3, 8'h40);
        bus_rd(2'd1, lo);
        bus_rd(2'd1, hi);
        check("R7 snapshot held, repeat ignored", {hi, lo}, 16'h0003);
        pulse_tick();
        check("R11 out low at count one", 16'(out[1]), 16'h0);
        pulse_tick();
        check("R11 out high after reload", 16'(out[1]), 16'h1);
        bus_wr(2'd3, 8'hC4);
        bus_rd(2'd1, lo);
        check("R8 status first", 16'(lo), 16'hB4);
        bus_rd(2'd1, lo);
        bus_rd(2'd1, hi);
        check("R8 count after status", {hi, lo}, 16'h0005);
        bus_rd(2'd1, lo);
        bus_rd(2'd1, hi);
        check("R6 live read lmsb", {hi, lo}, 16'h0005);
    endtask

    task automatic t_alias();
        logic [7:0] d;
        bus_wr(2'd3, 8'hBC);
        bus_wr(2'd3, 8'hE8);
        bus_rd(2'd2, d);
        check("R3 R4 alias folded in status", 16'(d), 16'hF4);
    endtask

    task automatic t_bytes_gate();
        logic [7:0] d;
        bus_wr(2'd3, 8'h90);
        bus_wr(2'd2, 8'h07);
        pulse_tick();
        gate[2] = 1'b0;
        pulse_tick();
        pulse_tick();
        bus_wr(2'd3, 8'h80);
        bus_rd(2'd2, d);
        check("R9 gate low holds count", 16'(d), 16'h07);
        gate[2] = 1'b1;
        pulse_tick();
        bus_rd(2'd2, d);
        check("R5 R6 low-only access", 16'(d), 16'h06);
        bus_wr(2'd3, 8'hA0);
        bus_wr(2'd2, 8'h02);
        pulse_tick();
        bus_wr(2'd3, 8'h80);
        bus_rd(2'd2, d);
        check("R5 high-only reload", 16'(d), 16'h02);
        pulse_tick();
        bus_rd(2'd2, d);
        check("R6 high-only live read", 16'(d), 16'h01);
    endtask

    task automatic t_zero_reload();
        logic [7:0] lo, hi;
        bus_wr(2'd3, 8'h35);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd0, 8'h00);
        pulse_tick();
        pulse_tick();
        bus_rd(2'd0, lo);
        bus_rd(2'd0, hi);
        check("R12 decimal zero reload", {hi, lo}, 16'h9999);
        check("R11 out high mid count", 16'(out[0]), 16'h1);
        bus_wr(2'd3, 8'h34);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd0, 8'h00);
        pulse_tick();
        pulse_tick();
        bus_wr(2'd3, 8'h00);
        bus_rd(2'd0, lo);
        bus_rd(2'd0, hi);
        check("R12 R7 binary zero reload", {hi, lo}, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_oneshot();
        t_periodic_snap();
        t_alias();
        t_bytes_gate();
        t_zero_reload();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            vectors++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule